// File: doc/BRIEF.md
# Fetch-Decode-Interrupt Cycle Sequencer

This block is the timing and control core of a small 16-bit accumulator machine. A 4-bit step counter is decoded into sixteen one-hot timing lines. The registers AR (12-bit address), PC (12-bit), IR (16-bit instruction), TR (16-bit temporary) and the addressing-mode bit all exchange data over one shared 16-bit bus. The block fetches and decodes instructions. It runs a hardware interrupt cycle that saves the program counter. It executes the two interrupt-enable instructions itself. It also raises an interrupt request when an attached device reports that it is ready.

Instruction words are laid out as follows: bit 15 is the addressing mode (0 direct, 1 indirect), bits 14..12 are the opcode, and bits 11..0 are an address. The 4096x16 memory sits outside the block. Its read data must follow the address output combinationally. It is written on the clock edge at which the write strobe is high, with the bus value as data.

Execution of all other instructions is left to a downstream executor. This block exposes the one-hot opcode lines, the mode bit and the timing lines to that executor. An internal stand-in executor finishes every instruction at step 3, so instructions take four cycles each. The interrupt service routine starts at word 1. It returns by an indirect branch through word 0, which holds the saved PC.

Top module: `cycle_sequencer`

## Requirements
- R1: A synchronous active-high reset clears the step counter, PC, AR, IR, TR, the mode bit, the interrupt enable and the interrupt request. After reset, timing line T0 is the only one high.
- R2: The step counter advances by one on every clock unless it is cleared, and `tState` is one-hot with bit n high at step n. Every instruction outside the interrupt cycle ends at T3, and T0 follows.
- R3: With no request pending: at T0, AR loads PC. At T1, IR loads the memory word at AR and PC increments. At T2, AR loads IR[11:0] and the mode bit loads IR[15].
- R4: `opDecode` is always the one-hot decode of IR[14:12], with bit k high for opcode k.
- R5: `busSel` names the single bus source with these codes: 0 none (bus reads 0), 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR, 7 memory word at AR. The codes for DR and AC belong to the executor and read as 0 here. In a fetch the sources are PC, then memory, then IR, then none at T3. In an interrupt cycle they are PC, then TR, then none.
- R6: At T3, when opcode 7 is decoded with mode bit 1 and IR[7] = 1 (interrupts on), the interrupt enable becomes 1.
- R7: At T3, when opcode 7 is decoded with mode bit 1, IR[7] = 0 and IR[6] = 1 (interrupts off), the interrupt enable becomes 0. IR[7] has priority over IR[6].
- R8: The interrupt request becomes 1 on an edge where the step is neither T0, T1 nor T2, the interrupt enable is 1, and `inFlag` or `outFlag` is high.
- R9: With a request pending: at T0, AR clears and TR loads PC. At T1, memory word 0 is written with TR (`memWe` high, `memAddr` 0, `busData` = saved PC) and PC clears.
- R10: At T2 of the interrupt cycle, PC increments to 1, and the interrupt enable, the request and the step counter all clear. The next fetch reads word 1.
- R11: The request never rises during T0, T1 or T2, or while the interrupt enable is 0. Device flags at those times have no effect.
- R12: Opcode 7 with mode bit 0, or with mode bit 1 and neither IR[7] nor IR[6] set, leaves the interrupt enable unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inFlag | input | 1 | Input device ready |
| outFlag | input | 1 | Output device ready |
| memRdata | input | 16 | Memory word at `memAddr` (combinational read) |
| memAddr | output | 12 | Memory address (AR) |
| busData | output | 16 | Shared bus value, also the memory write data |
| memWe | output | 1 | Memory write strobe |
| busSel | output | 3 | Bus source code |
| tState | output | 16 | One-hot timing lines T0..T15 |
| opDecode | output | 8 | One-hot opcode lines D0..D7 |
| indirect | output | 1 | Addressing-mode bit |
| ienOut | output | 1 | Interrupt enable |
| intReq | output | 1 | Interrupt request flip-flop |
| pcOut | output | 12 | Program counter |
| arOut | output | 12 | Address register |
| irOut | output | 16 | Instruction register |

## Verification
The embedded properties check, on every cycle, the invariants that hold at each step. T3 always wraps to T0, and the counter otherwise steps by one. The request never rises inside the fetch window or while interrupts are disabled. A retiring interrupt cycle leaves the request and the enable low and restarts at T0. Memory writes only ever target word 0. PC increments by exactly one, and AR and the mode bit are taken from the instruction register at T2.

Other behaviours need a whole sequence and only the bench scenarios can show them. These include the value stored in word 0, the restart from word 1, and the way the enable and disable instructions interleave with device flags. They also include the fact that a flag raised late in an instruction diverts exactly the next fetch, and that a reset in mid-run with a flag high still returns the clean state.

// File: rtl/seq_core_pkg.sv
package seq_core_pkg;

  // Bus source codes; values are decoded by the datapath mux.
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } busSrc_e;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    busSrc_e busSel;
    logic    arLoad;
    logic    arClear;
    logic    trLoad;
    logic    irLoad;
    logic    pcInc;
    logic    pcClear;
    logic    iLoad;
    logic    memWrite;
  } dpStrobes_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobes_t        strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] busData,
  output logic              memWe,
  output logic [(1<<OP_W)-1:0] opDecode,
  output logic              iBit,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [DATA_W-1:0] ir
);

  localparam int OP_CNT   = 1 << OP_W;
  localparam int OP_LSB   = ADDR_W;
  localparam int MODE_BIT = DATA_W - 1;
  localparam int PAD_W    = DATA_W - ADDR_W;

  logic [DATA_W-1:0] tr;
  logic [DATA_W-1:0] bus;

  // Single-source bus mux
  always_comb begin
    case (strobe.busSel)
      SRC_AR:  bus = {{PAD_W{1'b0}}, ar};
      SRC_PC:  bus = {{PAD_W{1'b0}}, pc};
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = memRdata;
      default: bus = '0;   // none, or executor-owned DR/AC
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ar   <= '0;
      pc   <= '0;
      ir   <= '0;
      tr   <= '0;
      iBit <= 1'b0;
    end else begin
      if (strobe.arClear)     ar <= '0;
      else if (strobe.arLoad) ar <= bus[ADDR_W-1:0];
      if (strobe.pcClear)     pc <= '0;
      else if (strobe.pcInc)  pc <= pc + ADDR_W'(1);
      if (strobe.irLoad)      ir <= bus;
      if (strobe.trLoad)      tr <= bus;
      if (strobe.iLoad)       iBit <= bus[MODE_BIT];
    end
  end

  // Opcode decoder
  for (genvar g = 0; g < OP_CNT; g++) begin : gOpDec
    assign opDecode[g] = (ir[OP_LSB +: OP_W] == OP_W'(g));
  end

  assign memAddr = ar;
  assign busData = bus;
  assign memWe   = strobe.memWrite;

  AST_WRITE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (memAddr == '0)); // R9

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.pcInc && !strobe.pcClear) |=> (pc == $past(pc) + ADDR_W'(1))); // R3

  AST_AR_FROM_IR: assert property (@(posedge clk) disable iff (rst)
    (strobe.arLoad && strobe.iLoad) |=>
      (ar == $past(ir[ADDR_W-1:0]) && iBit == $past(ir[MODE_BIT]))); // R3

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_core_pkg::*;
#(
  parameter int SC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inFlag,
  input  logic                 outFlag,
  input  logic                 scClear,
  input  logic                 ienSet,
  input  logic                 ienClr,
  output dpStrobes_t           strobe,
  output logic [(1<<SC_W)-1:0] tState,
  output logic                 ienOut,
  output logic                 intReq
);

  localparam int T_CNT = 1 << SC_W;

  logic [SC_W-1:0] sc;
  logic            fetchWindow;
  logic            intRetire;
  logic            devReady;

  // Timing decoder
  for (genvar g = 0; g < T_CNT; g++) begin : gTDec
    assign tState[g] = (sc == SC_W'(g));
  end

  assign fetchWindow = tState[0] | tState[1] | tState[2];
  assign intRetire   = intReq & tState[2];
  assign devReady    = inFlag | outFlag;

  // Strobe generation: fetch when no request, interrupt cycle otherwise
  always_comb begin
    strobe = '0;
    strobe.busSel = SRC_NONE;
    if (!intReq) begin
      if (tState[0]) begin
        strobe.busSel = SRC_PC;
        strobe.arLoad = 1'b1;
      end else if (tState[1]) begin
        strobe.busSel = SRC_MEM;
        strobe.irLoad = 1'b1;
        strobe.pcInc  = 1'b1;
      end else if (tState[2]) begin
        strobe.busSel = SRC_IR;
        strobe.arLoad = 1'b1;
        strobe.iLoad  = 1'b1;
      end
    end else begin
      if (tState[0]) begin
        strobe.busSel  = SRC_PC;
        strobe.arClear = 1'b1;
        strobe.trLoad  = 1'b1;
      end else if (tState[1]) begin
        strobe.busSel   = SRC_TR;
        strobe.memWrite = 1'b1;
        strobe.pcClear  = 1'b1;
      end else if (tState[2]) begin
        strobe.pcInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc     <= '0;
      ienOut <= 1'b0;
      intReq <= 1'b0;
    end else begin
      if (intRetire || scClear) sc <= '0;
      else                      sc <= sc + SC_W'(1);

      if (intRetire)   ienOut <= 1'b0;
      else if (ienSet) ienOut <= 1'b1;
      else if (ienClr) ienOut <= 1'b0;

      if (intRetire) intReq <= 1'b0;
      else if (!fetchWindow && ienOut && devReady) intReq <= 1'b1;
    end
  end

  AST_T3_WRAPS: assert property (@(posedge clk) disable iff (rst)
    tState[3] |=> tState[0]); // R2

  AST_SC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!scClear && !intRetire) |=> (sc == $past(sc) + SC_W'(1))); // R2

  AST_NO_REQ_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (!intReq && fetchWindow) |=> !intReq); // R11

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!intReq && !ienOut) |=> !intReq); // R11

  AST_INT_RETIRE: assert property (@(posedge clk) disable iff (rst)
    (intReq && tState[2]) |=> (!intReq && !ienOut && tState[0])); // R10

  AST_ION_SETS: assert property (@(posedge clk) disable iff (rst)
    ienSet |=> ienOut); // R6

  AST_IOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ienClr |=> !ienOut); // R7

endmodule

// File: rtl/seq_exec_stub.sv
module seq_exec_stub (
  input  logic execPhase,
  input  logic ioOpcode,
  input  logic indirect,
  input  logic ionBit,
  input  logic iofBit,
  output logic scClear,
  output logic ienSet,
  output logic ienClr
);

  logic ioInstr;

  // Every instruction retires at T3 in this stand-in executor.
  assign scClear = execPhase;
  assign ioInstr = execPhase & ioOpcode & indirect;
  assign ienSet  = ioInstr & ionBit;
  assign ienClr  = ioInstr & ~ionBit & iofBit;

  always_comb begin
    AST_ION_IOF_EXCL: assert (!(ienSet && ienClr)); // R7
  end

endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
  import seq_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 3,
  parameter int SC_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inFlag,
  input  logic                   outFlag,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      busData,
  output logic                   memWe,
  output logic [2:0]             busSel,
  output logic [(1<<SC_W)-1:0]   tState,
  output logic [(1<<OP_W)-1:0]   opDecode,
  output logic                   indirect,
  output logic                   ienOut,
  output logic                   intReq,
  output logic [ADDR_W-1:0]      pcOut,
  output logic [ADDR_W-1:0]      arOut,
  output logic [DATA_W-1:0]      irOut
);

  localparam int OP_CNT  = 1 << OP_W;
  localparam int ION_BIT = 7;
  localparam int IOF_BIT = 6;

  dpStrobes_t strobe;
  logic       scClear;
  logic       ienSet;
  logic       ienClr;

  seq_control #(.SC_W(SC_W)) u_control (
    .clk     (clk),
    .rst     (rst),
    .inFlag  (inFlag),
    .outFlag (outFlag),
    .scClear (scClear),
    .ienSet  (ienSet),
    .ienClr  (ienClr),
    .strobe  (strobe),
    .tState  (tState),
    .ienOut  (ienOut),
    .intReq  (intReq)
  );

  seq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .busData  (busData),
    .memWe    (memWe),
    .opDecode (opDecode),
    .iBit     (indirect),
    .pc       (pcOut),
    .ar       (arOut),
    .ir       (irOut)
  );

  seq_exec_stub u_exec (
    .execPhase (tState[3] & ~intReq),
    .ioOpcode  (opDecode[OP_CNT-1]),
    .indirect  (indirect),
    .ionBit    (irOut[ION_BIT]),
    .iofBit    (irOut[IOF_BIT]),
    .scClear   (scClear),
    .ienSet    (ienSet),
    .ienClr    (ienClr)
  );

  assign busSel = strobe.busSel;

endmodule

// File: tb/cycle_sequencer_bench.sv
module cycle_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_DEPTH  = 256;
  localparam int RUN_CYCLES = 260;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst, inFlag, outFlag;
  logic [15:0] memRdata;
  logic [11:0] memAddr;
  logic [15:0] busData;
  logic        memWe;
  logic [2:0]  busSel;
  logic [15:0] tState;
  logic [7:0]  opDecode;
  logic        indirect, ienOut, intReq;
  logic [11:0] pcOut, arOut;
  logic [15:0] irOut;

  cycle_sequencer u_cycle_sequencer (
    .clk(clk), .rst(rst), .inFlag(inFlag), .outFlag(outFlag),
    .memRdata(memRdata), .memAddr(memAddr), .busData(busData), .memWe(memWe),
    .busSel(busSel), .tState(tState), .opDecode(opDecode), .indirect(indirect),
    .ienOut(ienOut), .intReq(intReq), .pcOut(pcOut), .arOut(arOut), .irOut(irOut)
  );

  // Memory seen by the design
  logic [15:0] mem [MEM_DEPTH];
  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) if (memWe) mem[memAddr[7:0]] <= busData;

  // Behavioural reference state
  int mSc, mPc, mAr, mIr, mTr, mI, mIen, mR;
  int refMem [MEM_DEPTH];
  int checks = 0, fails = 0, intDone = 0;
  bit retPending = 0, finished = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic loadWord(int addr, int val);
    mem[addr] = 16'(val);
    refMem[addr] = val;
  endtask

  task automatic modelStep();
    int oIen;
    int nSc;
    bit flag;
    if (rst) begin
      mSc = 0; mPc = 0; mAr = 0; mIr = 0; mTr = 0; mI = 0; mIen = 0; mR = 0;
      return;
    end
    oIen = mIen;
    flag = inFlag | outFlag;
    nSc  = mSc + 1;
    if (mR == 0) begin
      case (mSc)
        0: mAr = mPc;
        1: begin mIr = refMem[mAr % MEM_DEPTH]; mPc = (mPc + 1) & 'hFFF; end
        2: begin mAr = mIr & 'hFFF; mI = (mIr >> 15) & 1; end
        default: ;
      endcase
      if (mSc == 3) begin
        nSc = 0;
        if (((mIr >> 12) & 7) == 7 && mI == 1) begin
          if ((mIr & 'h80) != 0)      mIen = 1;
          else if ((mIr & 'h40) != 0) mIen = 0;
        end
      end
      if (mSc >= 3 && oIen == 1 && flag) mR = 1;
      mSc = nSc;
    end else begin
      case (mSc)
        0: begin mAr = 0; mTr = mPc; end
        1: begin refMem[mAr % MEM_DEPTH] = mTr; mPc = 0; end
        default: begin
          mPc = (mPc + 1) & 'hFFF; mIen = 0; mR = 0; nSc = 0;
          intDone++; retPending = 1;
        end
      endcase
      mSc = nSc;
    end
  endtask

  task automatic compareAll();
    int expBus, expSel;
    expBus = 0; expSel = 0;
    if (mR == 0) begin
      case (mSc)
        0: begin expBus = mPc; expSel = 2; end
        1: begin expBus = refMem[mAr % MEM_DEPTH]; expSel = 7; end
        2: begin expBus = mIr; expSel = 5; end
        default: ;
      endcase
    end else begin
      case (mSc)
        0: begin expBus = mPc; expSel = 2; end
        1: begin expBus = mTr; expSel = 6; end
        default: ;
      endcase
    end
    chk("R2", "tState", int'(tState), 1 << mSc);
    chk("R3", "pc", int'(pcOut), mPc);
    chk("R3", "ar", int'(arOut), mAr);
    chk("R3", "ir", int'(irOut), mIr);
    chk("R3", "mode bit", int'(indirect), mI);
    chk("R4", "opDecode", int'(opDecode), 1 << ((mIr >> 12) & 7));
    chk("R5", "busSel", int'(busSel), expSel);
    chk("R5", "bus", int'(busData), expBus);
    chk("R9", "memWe", int'(memWe), int'(mR == 1 && mSc == 1));
    chk("R6 R7", "ien", int'(ienOut), mIen);
    chk("R8", "intReq", int'(intReq), mR);
  endtask

  task automatic resetChecks();
    chk("R1", "reset tState", int'(tState), 1);
    chk("R1", "reset pc", int'(pcOut), 0);
    chk("R1", "reset ar", int'(arOut), 0);
    chk("R1", "reset ir", int'(irOut), 0);
    chk("R1", "reset mode bit", int'(indirect), 0);
    chk("R1", "reset ien", int'(ienOut), 0);
    chk("R1", "reset intReq", int'(intReq), 0);
  endtask

  initial begin
    for (int a = 0; a < MEM_DEPTH; a++) begin
      mem[a] = '0;
      refMem[a] = 0;
    end
    loadWord(0, 'h7080);  // opcode 7, mode 0, bit 7 set: register form
    loadWord(1, 'hF080);  // interrupts on
    loadWord(2, 'hF200);  // opcode 7, mode 1, neither bit
    loadWord(3, 'hA123);
    loadWord(4, 'hF040);  // interrupts off
    loadWord(5, 'h2050);
    loadWord(6, 'hF080);  // interrupts on
    loadWord(7, 'h1004);
    loadWord(8, 'h3005);

    rst = 1'b1; inFlag = 1'b0; outFlag = 1'b0;
    modelStep();
    @(negedge clk);
    resetChecks();
    compareAll();

    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      rst     = (cyc >= 230 && cyc < 232);
      inFlag  = (cyc < 8) || (cyc >= 100 && cyc < 130) || (cyc >= 228 && cyc < 234);
      outFlag = (cyc >= 60 && cyc < 64);
      modelStep();
      @(negedge clk);
      compareAll();
      if (retPending) begin
        retPending = 0;
        chk("R10", "pc after interrupt", int'(pcOut), 1);
        chk("R10", "tState after interrupt", int'(tState), 1);
        chk("R10", "ien after interrupt", int'(ienOut), 0);
        chk("R9", "saved PC in word 0", int'(mem[0]), refMem[0]);
      end
      if (cyc < 8)   chk("R11", "flag ignored with ien off", int'(intReq), 0);
      if (cyc == 3)  chk("R12", "register-form opcode 7 ien", int'(ienOut), 0);
      if (cyc == 7)  chk("R6", "ien after interrupts-on", int'(ienOut), 1);
      if (cyc == 11) chk("R12", "plain I/O form keeps ien", int'(ienOut), 1);
      if (cyc == 19) chk("R7", "ien after interrupts-off", int'(ienOut), 0);
      if (cyc == 64) chk("R11", "late flag diverts next fetch", int'(intReq), 1);
      if (cyc == 66) chk("R9", "word 0 holds return address", int'(mem[0]), 16);
      if (cyc == 231) resetChecks();
    end
    chk("R8", "interrupts taken", int'(intDone > 1), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule